// File: doc/BRIEF.md
# Serial LED Display Control Register

This block is the receiving end of a slow serial configuration port on a dot-matrix LED display driver. A host drives four lines: a register select, an active-low chip enable, a serial clock and a data line. The block samples them with the system clock and shifts in an 8-bit word. Once the chip enable is released, it commits the word to one of two independent control words.

Control word 0 sets the LED brightness through pulse-width modulation, a 2-bit peak-current code and a sleep/normal flag. Control word 1 holds the data-out mode and a prescaler enable. The words that are already committed keep driving the outputs while a new word is being shifted in. They change only when a commit happens. While the block sleeps, the brightness PWM tick stops and the LED enable stays low. Both stored words are kept.

The serial lines are asynchronous to `clk_i` and pass through a synchronizer first. The host must hold each line level for several system clocks.

Top module: `led_ctrl_port`

## Requirements
- R1: After reset, control word 0 is in sleep with brightness 0 and peak code 0, and control word 1 has both bits 0. As a result, `sleep_o`=1, `led_en_o`=0, `peak_cur_o`=0, `dout_simul_o`=0 and `prescale_o`=0.
- R2: A control write is `rs_i` high, then `ce_ni` falling. While `ce_ni` is low, each rising `sclk_i` shifts `din_i` in, most significant bit first. The word is committed when `ce_ni` is high and `sclk_i` is low.
- R3: Bit 7 of the word picks the target: 0 writes control word 0 and 1 writes control word 1. The word that is not picked is left unchanged.
- R4: In control word 0, bits 3:0 are the brightness, bits 5:4 go to `peak_cur_o`, and bit 6 is the mode: 1 is normal and 0 is sleep (`sleep_o` = inverse of bit 6).
- R5: In control word 1, bit 0 drives `dout_simul_o` (1 = simultaneous, 0 = serial) and bit 1 drives `prescale_o`.
- R6: The PWM period is 16 ticks of `TICK_DIV` system clocks each. In normal mode `led_en_o` is high for brightness ticks of each period, so brightness 0 keeps it low.
- R7: In sleep, `led_en_o` is low and the PWM tick stops. Both control words keep their stored values.
- R8: The outputs do not change while a word is being shifted in, only at a commit.
- R9: If `ce_ni` returns high after a number of shifted bits other than 8, the word is dropped and neither control word changes.
- R10: A frame that starts with `rs_i` low when `ce_ni` falls is not a control write and changes nothing.
- R11: If `ce_ni` rises while `sclk_i` is still high, the commit waits until `sclk_i` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rs_i | input | 1 | Register select, high for control writes |
| ce_ni | input | 1 | Active-low chip enable |
| sclk_i | input | 1 | Serial shift clock |
| din_i | input | 1 | Serial data in |
| led_en_o | output | 1 | PWM LED enable |
| peak_cur_o | output | 2 | Peak pixel current code |
| sleep_o | output | 1 | High while in sleep mode |
| dout_simul_o | output | 1 | Data-out mode, 1 = simultaneous |
| prescale_o | output | 1 | Oscillator prescaler enable |

## Verification
Some properties are checked on every cycle: sleep forces the LED enable low, brightness 0 keeps it dark, the PWM phase freezes during sleep, no output moves without a commit, and a write to one word leaves the other unchanged. Only the bench scenarios can show the rest: that the shifted bits land in the right fields in MSB-first order, and that the duty cycle over one full period matches the brightness. The same holds for frames of 7 or 9 bits being dropped, frames with the register select low being ignored, and the commit waiting for the serial clock to fall.

// File: rtl/led_ctrl_pkg.sv
package led_ctrl_pkg;
  localparam int WORD_W   = 8;
  localparam int BRIGHT_W = 4;
  localparam int PEAK_W   = 2;
  localparam int SEL_BIT  = WORD_W - 1;

  typedef struct packed {
    logic                normal;
    logic [PEAK_W-1:0]   peak;
    logic [BRIGHT_W-1:0] bright;
  } cw0_t;

  typedef struct packed {
    logic prescale;
    logic simul;
  } cw1_t;

  localparam cw0_t CW0_RST = '{normal: 1'b0, peak: '0, bright: '0};
  localparam cw1_t CW1_RST = '{prescale: 1'b0, simul: 1'b0};
endpackage

// File: rtl/led_ctrl_sync.sv
module led_ctrl_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[g] <= RST_VAL;
      else if (g == 0) stg_q[g] <= d_i;
      else             stg_q[g] <= stg_q[(g > 0) ? g-1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/led_ctrl_rx.sv
module led_ctrl_rx
  import led_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rs_i,
  input  logic              ce_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  // bit order: rs, ce_n, sclk, din; ce_n idles high
  logic [3:0] raw, syn;
  assign raw = {rs_i, ce_ni, sclk_i, din_i};

  led_ctrl_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b0100)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  logic rs_s, ce_n_s, sclk_s, din_s;
  assign {rs_s, ce_n_s, sclk_s, din_s} = syn;

  logic              ce_n_q, sclk_q;
  logic              sel_q, armed_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sr_q;

  logic ce_fall, ce_rise, sclk_rise;
  assign ce_fall   =  ce_n_q & ~ce_n_s;
  assign ce_rise   = ~ce_n_q &  ce_n_s;
  assign sclk_rise = ~sclk_q &  sclk_s;

  // commit only in the CE-high / CLK-low window
  assign commit_o = armed_q & ce_n_s & ~sclk_s;
  assign word_o   = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      sel_q   <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sr_q    <= '0;
    end else begin
      ce_n_q <= ce_n_s;
      sclk_q <= sclk_s;
      if (ce_fall) begin
        cnt_q   <= '0;
        sel_q   <= rs_s;
        armed_q <= 1'b0;
      end else if (!ce_n_s && sclk_rise) begin
        sr_q  <= {sr_q[WORD_W-2:0], din_s};
        cnt_q <= (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
      end
      if (ce_rise)       armed_q <= sel_q && (cnt_q == CNT_FULL);
      else if (commit_o) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/led_ctrl_regs.sv
module led_ctrl_regs
  import led_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output cw0_t              cw0_o,
  output cw1_t              cw1_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cw0_o <= CW0_RST;
      cw1_o <= CW1_RST;
    end else if (commit_i) begin
      if (word_i[SEL_BIT]) cw1_o <= cw1_t'(word_i[$bits(cw1_t)-1:0]);
      else                 cw0_o <= cw0_t'(word_i[$bits(cw0_t)-1:0]);
    end
  end
endmodule

// File: rtl/led_ctrl_pwm.sv
module led_ctrl_pwm #(
  parameter int TICK_DIV = 4,
  parameter int PHASE_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_i,
  output logic [PHASE_W-1:0] phase_o
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             tick;
  assign tick = (div_q == DIV_LAST);

  // tick source frozen while asleep
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      phase_o <= '0;
    end else if (!sleep_i) begin
      if (tick) begin
        div_q   <= '0;
        phase_o <= phase_o + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/led_ctrl_port.sv
module led_ctrl_port
  import led_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TICK_DIV    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rs_i,
  input  logic              ce_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              led_en_o,
  output logic [PEAK_W-1:0] peak_cur_o,
  output logic              sleep_o,
  output logic              dout_simul_o,
  output logic              prescale_o
);
  logic                commit;
  logic [WORD_W-1:0]   rx_word;
  cw0_t                cw0_q;
  cw1_t                cw1_q;
  logic [BRIGHT_W-1:0] pwm_phase;

  led_ctrl_rx #(.SYNC_STAGES(SYNC_STAGES)) i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rs_i    (rs_i),
    .ce_ni   (ce_ni),
    .sclk_i  (sclk_i),
    .din_i   (din_i),
    .commit_o(commit),
    .word_o  (rx_word)
  );

  led_ctrl_regs i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(commit),
    .word_i  (rx_word),
    .cw0_o   (cw0_q),
    .cw1_o   (cw1_q)
  );

  led_ctrl_pwm #(.TICK_DIV(TICK_DIV), .PHASE_W(BRIGHT_W)) i_pwm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sleep_i(sleep_o),
    .phase_o(pwm_phase)
  );

  assign sleep_o      = ~cw0_q.normal;
  assign led_en_o     = cw0_q.normal && (pwm_phase < cw0_q.bright);
  assign peak_cur_o   = cw0_q.peak;
  assign dout_simul_o = cw1_q.simul;
  assign prescale_o   = cw1_q.prescale;
endmodule

// File: rtl/led_ctrl_port_chk.sv
module led_ctrl_port_chk
  import led_ctrl_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                commit_i,
  input logic [WORD_W-1:0]   word_i,
  input cw0_t                cw0_i,
  input cw1_t                cw1_i,
  input logic [BRIGHT_W-1:0] phase_i,
  input logic                led_en_o,
  input logic [PEAK_W-1:0]   peak_cur_o,
  input logic                sleep_o,
  input logic                dout_simul_o,
  input logic                prescale_o
);
  assert_sleep_dark_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> !led_en_o);

  assert_tick_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |=> $stable(phase_i));

  assert_zero_dark_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cw0_i.bright == '0) |-> !led_en_o);

  assert_hold_outputs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable({peak_cur_o, sleep_o, dout_simul_o, prescale_o}));

  assert_target_w0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !word_i[SEL_BIT]) |=> $stable(cw1_i));

  assert_target_w1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && word_i[SEL_BIT]) |=> $stable(cw0_i));
endmodule

bind led_ctrl_port led_ctrl_port_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .commit_i    (commit),
  .word_i      (rx_word),
  .cw0_i       (cw0_q),
  .cw1_i       (cw1_q),
  .phase_i     (pwm_phase),
  .led_en_o    (led_en_o),
  .peak_cur_o  (peak_cur_o),
  .sleep_o     (sleep_o),
  .dout_simul_o(dout_simul_o),
  .prescale_o  (prescale_o)
);

// File: tb/test_led_ctrl_port.sv
module test_led_ctrl_port;
  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 4;
  localparam int PERIOD_CYC = 16 * TICK;
  localparam int PH         = 4;
  localparam int WD_CYCLES  = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rs_i = 1'b0, ce_ni = 1'b1, sclk_i = 1'b0, din_i = 1'b0;
  logic led_en_o, sleep_o, dout_simul_o, prescale_o;
  logic [1:0] peak_cur_o;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_ctrl_port #(.SYNC_STAGES(2), .TICK_DIV(TICK)) i_led_ctrl_port (
    .clk_i(clk), .rst_ni(rst_ni), .rs_i(rs_i), .ce_ni(ce_ni),
    .sclk_i(sclk_i), .din_i(din_i), .led_en_o(led_en_o),
    .peak_cur_o(peak_cur_o), .sleep_o(sleep_o),
    .dout_simul_o(dout_simul_o), .prescale_o(prescale_o)
  );

  // {word, sleep, peak, simul, prescale, bright ticks}
  localparam logic [20:0] VEC [8] = '{
    {8'h4F, 1'b0, 2'd0, 1'b0, 1'b0, 8'd15},
    {8'h75, 1'b0, 2'd3, 1'b0, 1'b0, 8'd5},
    {8'h60, 1'b0, 2'd2, 1'b0, 1'b0, 8'd0},
    {8'h81, 1'b0, 2'd2, 1'b1, 1'b0, 8'd0},
    {8'h83, 1'b0, 2'd2, 1'b1, 1'b1, 8'd0},
    {8'h18, 1'b1, 2'd1, 1'b1, 1'b1, 8'd0},
    {8'h58, 1'b0, 2'd1, 1'b1, 1'b1, 8'd8},
    {8'h80, 1'b0, 2'd1, 1'b0, 1'b0, 8'd8}
  };

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic begin_frame(input logic rs);
    rs_i = rs;  wait_clks(PH);
    ce_ni = 1'b0; wait_clks(PH);
  endtask

  task automatic shift_bit(input logic b);
    sclk_i = 1'b0; din_i = b; wait_clks(PH);
    sclk_i = 1'b1; wait_clks(PH);
  endtask

  task automatic end_frame(input bit hold_high);
    ce_ni = 1'b1; wait_clks(PH);
    if (!hold_high) begin
      sclk_i = 1'b0; wait_clks(10);
    end
  endtask

  task automatic send(input int nbits, input logic [15:0] val, input logic rs);
    begin_frame(rs);
    for (int i = nbits - 1; i >= 0; i--) shift_bit(val[i]);
    end_frame(1'b0);
  endtask

  task automatic duty(output int hi);
    hi = 0;
    repeat (PERIOD_CYC) begin
      @(negedge clk);
      if (led_en_o) hi++;
    end
  endtask

  task automatic check_state(input string req, input int slp, input int pk,
                             input int sim, input int pre);
    check({req, " sleep"},    sleep_o,      slp);
    check({req, " peak"},     peak_cur_o,   pk);
    check({req, " simul"},    dout_simul_o, sim);
    check({req, " prescale"}, prescale_o,   pre);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin : stim
    int hi;
    wait_clks(3);
    rst_ni = 1'b1;
    wait_clks(4);
    // R1 reset state
    check_state("R1", 1, 0, 0, 0);
    duty(hi);
    check("R1 led_en after reset", hi, 0);

    // R2 R3 R4 R5 R6 R7 table walk
    foreach (VEC[k]) begin
      send(8, {8'h00, VEC[k][20:13]}, 1'b1);
      check_state($sformatf("R2/R4/R5 vec%0d", k), VEC[k][12], VEC[k][11:10],
                  VEC[k][9], VEC[k][8]);
      duty(hi);
      check($sformatf("R6/R7 duty vec%0d", k), hi, VEC[k][7:0] * TICK);
    end
    // word0 now 0x58, word1 0x80

    // R8 outputs hold mid-shift
    begin_frame(1'b1);
    for (int i = 7; i >= 4; i--) shift_bit(8'h6A >> i);
    check_state("R8 mid-shift", 0, 1, 0, 0);
    for (int i = 3; i >= 0; i--) shift_bit(8'h6A >> i);
    check_state("R8 before CE release", 0, 1, 0, 0);
    end_frame(1'b0);
    check("R8 commit peak", peak_cur_o, 2);
    duty(hi);
    check("R8 commit duty", hi, 10 * TICK);

    // R9 short and long frames dropped
    send(7, 16'h0027, 1'b1);
    check_state("R9 7-bit frame", 0, 2, 0, 0);
    send(9, 16'h014F, 1'b1);
    check_state("R9 9-bit frame", 0, 2, 0, 0);
    duty(hi);
    check("R9 duty kept", hi, 10 * TICK);

    // R10 rs low frame ignored
    send(8, 16'h0040, 1'b0);
    check_state("R10 rs low", 0, 2, 0, 0);
    send(8, 16'h0083, 1'b0);
    check_state("R10 rs low word1", 0, 2, 0, 0);

    // R11 commit waits for sclk low
    begin_frame(1'b1);
    for (int i = 7; i >= 0; i--) shift_bit(8'h53 >> i);
    end_frame(1'b1);
    wait_clks(12);
    check("R11 held while sclk high", peak_cur_o, 2);
    sclk_i = 1'b0; wait_clks(8);
    check("R11 commit after sclk low", peak_cur_o, 1);
    duty(hi);
    check("R11 duty", hi, 3 * TICK);

    // R7 sleep retains both words
    send(8, 16'h0083, 1'b1);
    send(8, 16'h0033, 1'b1);
    check_state("R7 sleep entry", 1, 3, 1, 1);
    duty(hi);
    check("R7 dark in sleep", hi, 0);
    send(8, 16'h0073, 1'b1);
    check_state("R7 wake", 0, 3, 1, 1);
    duty(hi);
    check("R7 duty after wake", hi, 3 * TICK);

    // R1 reset mid-run
    rst_ni = 1'b0; wait_clks(2);
    check_state("R1 in reset", 1, 0, 0, 0);
    check("R1 led_en in reset", led_en_o, 0);
    rst_ni = 1'b1; wait_clks(4);
    duty(hi);
    check("R1 dark after reset", hi, 0);

    finish_run();
  end
endmodule